// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register File

This block is the control register file of an audio codec. It answers a simple word-addressed 32-bit bus inside a 64-byte window, which holds sixteen 32-bit direct words. Direct word 0 holds a pointer. Its low five bits pick one of thirty-two 8-bit indirect registers. Direct word 1 is a port: a read or a write to word 1 reaches the indirect register that the pointer names. Every other direct word has its own storage.

Some registers follow special access rules. One indirect slot accepts writes but always reads back zero. Two slots ignore writes. One slot carries a fixed version code and stores only one writable bit. Direct word 2 ignores writes. A write to direct word 4 with bit 0 set returns the whole file to its reset state. The block then stores the low seven bits of the written value in word 4. The interrupt output is present but is held low.

Each access is classified combinationally into one of four access kinds, chosen by a `unique case` on the word number: `ACC_PLAIN` (own storage), `ACC_PORT` (indirect access through the pointer), `ACC_LOCKED` (writes dropped) and `ACC_CTRL` (masked store, with soft reset when bit 0 is set). The block has no sequential controller. Every access completes in the cycle of its strobe, so no kind leads to another.

Top module: `codec_ctl_regs`

## Requirements
- R1: After reset every direct word reads 0x00000000. Every indirect register reads 0x00, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0.
- R2: A write to any direct word other than 1, 2 and 4 stores the full 32-bit value, and a later read of that word returns it.
- R3: Bits [4:0] of direct word 0 select the indirect register. A read of word 1 returns that register zero-extended to 32 bits. A write to word 1 stores bus bits [7:0] in that register. Bits [31:5] of word 0 are kept in word 0 but do not affect the selection.
- R4: Indirect register 3 takes writes, but a read of it through word 1 always returns 0.
- R5: A write through word 1 to indirect register 11 or 25 leaves that register unchanged.
- R6: A write through word 1 to indirect register 12 stores (data & 0x40) | 0x8A.
- R7: A write to direct word 2 is ignored, and the word keeps reading 0.
- R8: A write to direct word 4 with bit 0 set returns all registers to their R1 values on that clock edge, except word 4. Word 4 takes data & 0x7F.
- R9: A write to direct word 4 with bit 0 clear stores data & 0x7F and resets nothing.
- R10: The word number is address bits [5:2]. Address bits [1:0] have no effect.
- R11: The read data is 0 whenever the read strobe is low. With the read strobe high, it shows the selected word in the same cycle.
- R12: The interrupt output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, giving the same state as a soft reset |
| bus_addr | input | 6 | Byte address within the window |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_o | output | 1 | Interrupt, held low |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that a strobe is qualified only by a defined address. The bench drives the strobes and the address together at falling edges and drops the strobes before the next access. A write therefore lands on a single rising edge, and a combinational read is sampled while its inputs are stable. Soft-reset writes are always separate accesses, so a port write and a control write never share an edge. This keeps the one-cycle checks of reset and masking well defined.

// File: rtl/cdc_reg_pkg.sv
package cdc_reg_pkg;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 32;
    localparam int WORD_COUNT = 16;
    localparam int IND_COUNT  = 32;
    localparam int IND_W      = 8;
    localparam int WSEL_W     = $clog2(WORD_COUNT);
    localparam int IDX_W      = $clog2(IND_COUNT);

    // direct word numbers whose behaviour is special
    localparam int W_POINTER  = 0;
    localparam int W_PORT     = 1;
    localparam int W_LOCKED   = 2;
    localparam int W_CTRL     = 4;

    // indirect slots with special rules
    localparam int I_WONLY    = 3;
    localparam int I_FROZEN   = 11;
    localparam int I_VERSION  = 12;
    localparam int I_IDCODE   = 25;

    localparam logic [IND_W-1:0]  VERSION_CODE = 8'h8A;
    localparam logic [IND_W-1:0]  ID_CODE      = 8'hA0;
    localparam logic [IND_W-1:0]  VERSION_KEEP = 8'h40;
    localparam logic [DATA_W-1:0] CTRL_KEEP    = 32'h0000_007F;

    typedef enum logic [1:0] {
        ACC_PLAIN,
        ACC_PORT,
        ACC_LOCKED,
        ACC_CTRL
    } acc_e;

    function automatic logic [IND_W-1:0] ind_reset_value(input int slot);
        if (slot == I_VERSION)     return VERSION_CODE;
        else if (slot == I_IDCODE) return ID_CODE;
        else                       return '0;
    endfunction
endpackage

// File: rtl/cdc_access_decode.sv
module cdc_access_decode
    import cdc_reg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = WSEL_W
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [SW-1:0] word,
    output acc_e          kind,
    output logic          plain_we,
    output logic          port_we,
    output logic          ctrl_we,
    output logic          soft_rst
);
    assign word = addr[AW-1:2];

    always_comb begin
        unique case (word)
            SW'(W_PORT):   kind = ACC_PORT;
            SW'(W_LOCKED): kind = ACC_LOCKED;
            SW'(W_CTRL):   kind = ACC_CTRL;
            default:       kind = ACC_PLAIN;
        endcase
    end

    always_comb begin
        plain_we = 1'b0;
        port_we  = 1'b0;
        ctrl_we  = 1'b0;
        unique case (kind)
            ACC_PLAIN:  plain_we = wr;
            ACC_PORT:   port_we  = wr;
            ACC_CTRL:   ctrl_we  = wr;
            ACC_LOCKED: ;
        endcase
    end

    assign soft_rst = ctrl_we & wdata[0];
endmodule

// File: rtl/cdc_direct_file.sv
module cdc_direct_file
    import cdc_reg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NW = WORD_COUNT,
    parameter int IW = IDX_W,
    localparam int SW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          plain_we,
    input  logic          ctrl_we,
    input  logic          soft_rst,
    input  logic [SW-1:0] word,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_word,
    output logic [IW-1:0] pointer
);
    logic [DW-1:0] regs_q [NW];

    generate
        for (genvar g = 0; g < NW; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else if (g == W_CTRL) begin
                    if (ctrl_we) regs_q[g] <= wdata & CTRL_KEEP;
                end else if (soft_rst) begin
                    regs_q[g] <= '0;
                end else if (plain_we && word == SW'(g)) begin
                    regs_q[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rd_word = regs_q[word];
    assign pointer = regs_q[W_POINTER][IW-1:0];

    assert_locked_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> regs_q[W_LOCKED] == '0);

    assert_soft_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_q[W_POINTER] == '0) &&
                     (regs_q[W_CTRL] == ($past(wdata) & CTRL_KEEP)));

    assert_ctrl_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> regs_q[W_CTRL][DW-1:7] == '0);
endmodule

// File: rtl/cdc_indirect_file.sv
module cdc_indirect_file
    import cdc_reg_pkg::*;
#(
    parameter int NI = IND_COUNT,
    parameter int BW = IND_W,
    localparam int IW = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_we,
    input  logic          soft_rst,
    input  logic [IW-1:0] pointer,
    input  logic [BW-1:0] wbyte,
    output logic [BW-1:0] rd_byte
);
    logic [BW-1:0] regs_q [NI];

    generate
        for (genvar g = 0; g < NI; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) begin
                    regs_q[g] <= ind_reset_value(g);
                end else if (port_we && pointer == IW'(g)) begin
                    if (g == I_VERSION)
                        regs_q[g] <= (wbyte & VERSION_KEEP) | VERSION_CODE;
                    else if (g != I_FROZEN && g != I_IDCODE)
                        regs_q[g] <= wbyte;
                end
            end
        end
    endgenerate

    assign rd_byte = (pointer == IW'(I_WONLY)) ? '0 : regs_q[pointer];

    assert_frozen_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && (pointer == IW'(I_FROZEN) || pointer == IW'(I_IDCODE)))
        |=> $stable(regs_q[I_FROZEN]) && $stable(regs_q[I_IDCODE]));

    assert_version_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && pointer == IW'(I_VERSION))
        |=> regs_q[I_VERSION] == (($past(wbyte) & VERSION_KEEP) | VERSION_CODE));

    assert_soft_reset_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_q[I_VERSION] == VERSION_CODE) && (regs_q[I_IDCODE] == ID_CODE));
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
    import cdc_reg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NW = WORD_COUNT,
    parameter int NI = IND_COUNT,
    parameter int BW = IND_W,
    localparam int SW = $clog2(NW),
    localparam int IW = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);
    logic [SW-1:0] word;
    acc_e          kind;
    logic          plain_we, port_we, ctrl_we, soft_rst;
    logic [DW-1:0] dir_word;
    logic [IW-1:0] pointer;
    logic [BW-1:0] ind_byte;

    cdc_access_decode #(.AW(AW), .DW(DW), .SW(SW)) u_decode (
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .word(word), .kind(kind), .plain_we(plain_we),
        .port_we(port_we), .ctrl_we(ctrl_we), .soft_rst(soft_rst)
    );

    cdc_direct_file #(.DW(DW), .NW(NW), .IW(IW)) u_direct (
        .clk(clk), .rst_n(rst_n), .plain_we(plain_we), .ctrl_we(ctrl_we),
        .soft_rst(soft_rst), .word(word), .wdata(bus_wdata),
        .rd_word(dir_word), .pointer(pointer)
    );

    cdc_indirect_file #(.NI(NI), .BW(BW)) u_indirect (
        .clk(clk), .rst_n(rst_n), .port_we(port_we), .soft_rst(soft_rst),
        .pointer(pointer), .wbyte(bus_wdata[BW-1:0]), .rd_byte(ind_byte)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (kind)
                ACC_PORT:                      bus_rdata = DW'(ind_byte);
                ACC_PLAIN, ACC_LOCKED, ACC_CTRL: bus_rdata = dir_word;
            endcase
        end
    end

    assign irq_o = 1'b0;

    assert_wonly_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == ACC_PORT && pointer == IW'(I_WONLY)) |-> bus_rdata == '0);

    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

    assert_port_zero_extend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == ACC_PORT) |-> bus_rdata[DW-1:BW] == '0);
endmodule

// File: tb/test_codec_ctl_regs.sv
module test_codec_ctl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;

    codec_ctl_regs i_codec_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_ind(input int slot, output logic [31:0] d);
        bus_write(6'h00, 32'(slot));
        bus_read(6'h04, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int w = 0; w < 16; w++) begin
            if (w == 1) continue;
            bus_read(6'(w*4), d);
            check("R1 direct reset", d, 32'h0);
        end
        for (int s = 0; s < 32; s++) begin
            read_ind(s, d);
            check("R1 indirect reset", d,
                  s == 12 ? 32'h8A : (s == 25 ? 32'hA0 : 32'h0));
        end
    endtask

    task automatic t_direct;
        logic [31:0] d;
        bus_write(6'h0C, 32'hDEAD_BEEF);
        bus_write(6'h3C, 32'h1234_5678);
        bus_read(6'h0C, d); check("R2 word3", d, 32'hDEAD_BEEF);
        bus_read(6'h3C, d); check("R2 word15", d, 32'h1234_5678);
        bus_write(6'h23, 32'hA5A5_0001);
        bus_read(6'h20, d); check("R10 low addr bits ignored on write", d, 32'hA5A5_0001);
        bus_read(6'h22, d); check("R10 low addr bits ignored on read", d, 32'hA5A5_0001);
    endtask

    task automatic t_port;
        logic [31:0] d;
        bus_write(6'h00, 32'hFFFF_FFE7);
        bus_write(6'h04, 32'hCAFE_F05C);
        bus_read(6'h04, d); check("R3 port byte write and zero-extend", d, 32'h5C);
        bus_read(6'h00, d); check("R3 pointer word keeps upper bits", d, 32'hFFFF_FFE7);
        bus_write(6'h00, 32'h0000_0006);
        bus_write(6'h04, 32'h0000_0033);
        bus_read(6'h04, d); check("R3 slot 6", d, 32'h33);
        read_ind(7, d); check("R3 slot 7 via pointer", d, 32'h5C);
    endtask

    task automatic t_wonly;
        logic [31:0] d;
        bus_write(6'h00, 32'd3);
        bus_write(6'h04, 32'h77);
        bus_read(6'h04, d); check("R4 write-only slot reads zero", d, 32'h0);
    endtask

    task automatic t_frozen;
        logic [31:0] d;
        bus_write(6'h00, 32'd11);
        bus_write(6'h04, 32'hFF);
        bus_read(6'h04, d); check("R5 slot 11 ignores write", d, 32'h0);
        bus_write(6'h00, 32'd25);
        bus_write(6'h04, 32'h11);
        bus_read(6'h04, d); check("R5 slot 25 ignores write", d, 32'hA0);
    endtask

    task automatic t_version;
        logic [31:0] d;
        bus_write(6'h00, 32'd12);
        bus_write(6'h04, 32'hFF);
        bus_read(6'h04, d); check("R6 version bit 6 set", d, 32'hCA);
        bus_write(6'h04, 32'h35);
        bus_read(6'h04, d); check("R6 version bit 6 clear", d, 32'h8A);
    endtask

    task automatic t_locked;
        logic [31:0] d;
        bus_write(6'h08, 32'hFFFF_FFFF);
        bus_read(6'h08, d); check("R7 word2 ignores write", d, 32'h0);
    endtask

    task automatic t_ctrl_plain;
        logic [31:0] d;
        bus_write(6'h14, 32'h0BAD_0001);
        bus_write(6'h10, 32'hFFFF_FFFE);
        bus_read(6'h10, d); check("R9 ctrl masked store", d, 32'h7E);
        bus_read(6'h14, d); check("R9 no reset of word5", d, 32'h0BAD_0001);
    endtask

    task automatic t_soft_reset;
        logic [31:0] d;
        bus_write(6'h18, 32'h5555_AAAA);
        bus_write(6'h00, 32'd9);
        bus_write(6'h04, 32'h9C);
        bus_write(6'h00, 32'd12);
        bus_write(6'h04, 32'h40);
        bus_write(6'h10, 32'hFFFF_FFFF);
        bus_read(6'h10, d); check("R8 ctrl keeps low 7 bits", d, 32'h7F);
        bus_read(6'h18, d); check("R8 word6 cleared", d, 32'h0);
        bus_read(6'h00, d); check("R8 pointer cleared", d, 32'h0);
        bus_read(6'h04, d); check("R8 slot 0 via cleared pointer", d, 32'h0);
        read_ind(9, d);  check("R8 slot 9 cleared", d, 32'h0);
        read_ind(12, d); check("R8 version restored", d, 32'h8A);
        read_ind(25, d); check("R8 id restored", d, 32'hA0);
    endtask

    task automatic t_idle_and_irq;
        bus_write(6'h1C, 32'hFEED_F00D);
        @(negedge clk);
        bus_addr = 6'h1C; bus_rd = 1'b0;
        #1 check("R11 rdata zero without read strobe", bus_rdata, 32'h0);
        check("R12 irq low", {31'h0, irq_o}, 32'h0);
        bus_rd = 1'b1;
        #1 check("R11 rdata same cycle", bus_rdata, 32'hFEED_F00D);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_port();
        t_wonly();
        t_frozen();
        t_version();
        t_locked();
        t_ctrl_plain();
        t_soft_reset();
        t_idle_and_irq();
        check("R12 irq low at end", {31'h0, irq_o}, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule